// File: doc/BRIEF.md
# Automatic Software Flow Controller

This block sits beside a UART and does XON/XOFF flow control with no help from software. On the receive side it compares each received character against four programmable control codes (two "resume" codes and two "pause" codes). A match pauses or releases the local transmitter through `tx_pause`. Matched control characters are swallowed and never reach the receive FIFO. All other characters go out on the forward port one cycle later.

On the transmit side the block watches the receive FIFO fill level. When the level reaches the halt threshold, it asks the transmitter to insert a pause code. When the level drains to the resume threshold, it asks for a resume code. Each request is made once, and the opposite event re-arms it.

A 2-bit mode per direction selects which codes are used. Each mode uses either code set 1, code set 2, or both sets as back-to-back pairs. A master enable gates everything. Every detection raises a one-cycle flag.

Top module: `swflow_ctrl`

## Requirements
- R1: After reset, `tx_pause`, `fwd_valid`, `ins_valid` and `det_flags` are all 0.
- R2: With `cfg_en` low, or with `cfg_rx_mode` = 00, every received character is forwarded unchanged in the cycle after it arrives, and no flag is raised. In these conditions `tx_pause` reads 0, including when it was set before.
- R3: With `cfg_rx_mode` = 10, a character equal to `cfg_xoff1` sets `tx_pause` and raises `det_flags` bit 2. A character equal to `cfg_xon1` clears `tx_pause` and raises bit 0. Both take effect in the cycle after the character, and neither character is forwarded. Set-2 codes are forwarded as data.
- R4: With `cfg_rx_mode` = 01, `cfg_xoff2` and `cfg_xon2` act in the same way, using flag bits 3 and 1. Set-1 codes are forwarded as data.
- R5: With `cfg_rx_mode` = 11, only the pair `cfg_xoff1` then `cfg_xoff2` pauses the transmitter, raising flag bits 3 and 2. Only the pair `cfg_xon1` then `cfg_xon2` releases it, raising bits 1 and 0. A first code on its own produces no output and leaves `tx_pause` unchanged.
- R6: In mode 11, when a held first code is followed by a character that does not complete its pair, the held code is forwarded in the cycle after the second character arrives. If the second character is not itself a first code, it is forwarded one cycle after that; if it is a first code, it becomes the new held code. Received characters must be spaced by at least one idle cycle.
- R7: A character received with `rx_break` high raises `det_flags` bit 4 in the next cycle. The character is forwarded as data and is never treated as a control code.
- R8: With `cfg_en` high and `cfg_tx_mode` not 00, `fifo_level` reaching `cfg_levels[3:0]`×8 or more produces one `ins_valid` pulse in the next cycle. The pulse carries `cfg_xoff1` in mode 10 and `cfg_xoff2` in mode 01. Further levels at or above the threshold produce nothing more.
- R9: After a pause request, `fifo_level` at or below `cfg_levels[7:4]`×8 produces one `ins_valid` pulse in the next cycle. The pulse carries `cfg_xon1` in mode 10 and `cfg_xon2` in mode 01. After that, no further resume request is made.
- R10: With `cfg_tx_mode` = 11, each request is two pulses on consecutive cycles: set 1 first, then set 2.
- R11: With `cfg_en` low or `cfg_tx_mode` = 00, `ins_valid` stays low for any FIFO level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_en | input | 1 | Master enable for all automatic flow control |
| cfg_rx_mode | input | 2 | Receive matching mode: 00 off, 01 set 2, 10 set 1, 11 pairs |
| cfg_tx_mode | input | 2 | Transmit insertion mode: 00 off, 01 set 2, 10 set 1, 11 pairs |
| cfg_levels | input | 8 | [3:0] halt threshold, [7:4] resume threshold, units of 8 entries |
| cfg_xon1 | input | 8 | Resume code, set 1 |
| cfg_xon2 | input | 8 | Resume code, set 2 |
| cfg_xoff1 | input | 8 | Pause code, set 1 |
| cfg_xoff2 | input | 8 | Pause code, set 2 |
| rx_valid | input | 1 | Received character strobe |
| rx_char | input | 8 | Received character |
| rx_break | input | 1 | Received character is a break |
| fifo_level | input | 8 | Receive FIFO fill level, 0 to 128 |
| tx_pause | output | 1 | Hold the local transmitter |
| ins_valid | output | 1 | Request to insert a flow character |
| ins_char | output | 8 | Character to insert |
| fwd_valid | output | 1 | Character to write into the receive FIFO |
| fwd_char | output | 8 | Forwarded character |
| det_flags | output | 5 | One-cycle detect flags: 0 xon1, 1 xon2, 2 xoff1, 3 xoff2, 4 break |

## Verification
Most results come from a single register stage and are due exactly one cycle after the character or level change that causes them. Two results come a cycle later: the second character of a broken pair, and the second pulse of a paired insertion. The driver stamps each expected forward, insert or flag item with the cycle it is due, and the monitor compares that stamp with a free-running cycle count. An early, late, extra or missing item therefore fails. `tx_pause` is sampled a few idle cycles after each character.

// File: rtl/swflow_ctrl.sv
module swflow_ctrl #(
  parameter int FIFO_DEPTH = 128,
  parameter int CHW        = 8,
  parameter int THR_UNIT   = 8,
  localparam int LVLW      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_en,
  input  logic [1:0]      cfg_rx_mode,
  input  logic [1:0]      cfg_tx_mode,
  input  logic [7:0]      cfg_levels,
  input  logic [CHW-1:0]  cfg_xon1,
  input  logic [CHW-1:0]  cfg_xon2,
  input  logic [CHW-1:0]  cfg_xoff1,
  input  logic [CHW-1:0]  cfg_xoff2,
  input  logic            rx_valid,
  input  logic [CHW-1:0]  rx_char,
  input  logic            rx_break,
  input  logic [LVLW-1:0] fifo_level,
  output logic            tx_pause,
  output logic            ins_valid,
  output logic [CHW-1:0]  ins_char,
  output logic            fwd_valid,
  output logic [CHW-1:0]  fwd_char,
  output logic [4:0]      det_flags
);
  localparam int CW = LVLW + 4;

  logic en_rx, en_tx, use1, use2, pair_mode;
  logic is_on1, is_on2, is_off1, is_off2;
  logic first_ok, pair_done, single_on, single_off;
  logic pause_q, pend_v, pend_off, stash_v, off_sent, second_v;
  logic [CHW-1:0] pend_c, stash_c, second_c;
  logic [CW-1:0] halt_lvl, resume_lvl, lvl;

  assign en_rx     = cfg_en && (cfg_rx_mode != 2'b00);
  assign en_tx     = cfg_en && (cfg_tx_mode != 2'b00);
  assign use1      = en_rx && (cfg_rx_mode == 2'b10);
  assign use2      = en_rx && (cfg_rx_mode == 2'b01);
  assign pair_mode = en_rx && (cfg_rx_mode == 2'b11);

  assign is_on1  = !rx_break && (rx_char == cfg_xon1);
  assign is_on2  = !rx_break && (rx_char == cfg_xon2);
  assign is_off1 = !rx_break && (rx_char == cfg_xoff1);
  assign is_off2 = !rx_break && (rx_char == cfg_xoff2);

  assign first_ok   = pair_mode && (is_on1 || is_off1);
  assign pair_done  = pair_mode && pend_v && (pend_off ? is_off2 : is_on2);
  assign single_off = (use1 && is_off1) || (use2 && is_off2);
  assign single_on  = (use1 && is_on1) || (use2 && is_on2);

  assign tx_pause = pause_q && en_rx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pause_q   <= 1'b0;
      pend_v    <= 1'b0;
      pend_off  <= 1'b0;
      pend_c    <= '0;
      stash_v   <= 1'b0;
      stash_c   <= '0;
      fwd_valid <= 1'b0;
      fwd_char  <= '0;
      det_flags <= '0;
    end else begin
      fwd_valid <= 1'b0;
      det_flags <= '0;
      if (!en_rx) pause_q <= 1'b0;
      if (stash_v) begin
        fwd_valid <= 1'b1;
        fwd_char  <= stash_c;
        stash_v   <= 1'b0;
      end
      if (rx_valid) begin
        det_flags[4] <= rx_break;
        if (pend_v) begin
          pend_v <= 1'b0;
          if (pair_done) begin
            det_flags[3:0] <= pend_off ? 4'b1100 : 4'b0011;
            pause_q        <= pend_off;
          end else begin
            fwd_valid <= 1'b1;
            fwd_char  <= pend_c;
            if (first_ok) begin
              pend_v   <= 1'b1;
              pend_off <= is_off1;
              pend_c   <= rx_char;
            end else begin
              stash_v <= 1'b1;
              stash_c <= rx_char;
            end
          end
        end else if (first_ok) begin
          pend_v   <= 1'b1;
          pend_off <= is_off1;
          pend_c   <= rx_char;
        end else if (single_off) begin
          det_flags[3:0] <= use1 ? 4'b0100 : 4'b1000;
          pause_q        <= 1'b1;
        end else if (single_on) begin
          det_flags[3:0] <= use1 ? 4'b0001 : 4'b0010;
          pause_q        <= 1'b0;
        end else begin
          fwd_valid <= 1'b1;
          fwd_char  <= rx_char;
        end
      end
    end
  end

  assign halt_lvl   = CW'(cfg_levels[3:0]) * CW'(THR_UNIT);
  assign resume_lvl = CW'(cfg_levels[7:4]) * CW'(THR_UNIT);
  assign lvl        = CW'(fifo_level);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_sent  <= 1'b0;
      second_v  <= 1'b0;
      second_c  <= '0;
      ins_valid <= 1'b0;
      ins_char  <= '0;
    end else begin
      ins_valid <= 1'b0;
      if (!en_tx) begin
        off_sent <= 1'b0;
        second_v <= 1'b0;
      end else if (second_v) begin
        ins_valid <= 1'b1;
        ins_char  <= second_c;
        second_v  <= 1'b0;
      end else if (!off_sent && lvl >= halt_lvl) begin
        off_sent  <= 1'b1;
        ins_valid <= 1'b1;
        ins_char  <= (cfg_tx_mode == 2'b01) ? cfg_xoff2 : cfg_xoff1;
        second_v  <= (cfg_tx_mode == 2'b11);
        second_c  <= cfg_xoff2;
      end else if (off_sent && lvl <= resume_lvl) begin
        off_sent  <= 1'b0;
        ins_valid <= 1'b1;
        ins_char  <= (cfg_tx_mode == 2'b01) ? cfg_xon2 : cfg_xon1;
        second_v  <= (cfg_tx_mode == 2'b11);
        second_c  <= cfg_xon2;
      end
    end
  end
endmodule

// File: rtl/swflow_ctrl_chk.sv
module swflow_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_en,
  input logic [1:0] cfg_tx_mode,
  input logic       rx_valid,
  input logic       tx_pause,
  input logic       ins_valid,
  input logic       fwd_valid,
  input logic [4:0] det_flags
);
  AST_INS_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    ins_valid |-> ($past(cfg_en) && $past(cfg_tx_mode) != 2'b00)); // R11
  AST_PAUSE_ON_XOFF: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_pause) |-> (det_flags[2] || det_flags[3])); // R3
  AST_FWD_FOLLOWS_RX: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid |-> ($past(rx_valid) || $past(rx_valid, 2))); // R6
  AST_FLAG_FOLLOWS_RX: assert property (@(posedge clk) disable iff (!rst_n)
    (det_flags != 5'd0) |-> $past(rx_valid)); // R7
  AST_PAIR_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(det_flags[3:0]) == 2) |-> (det_flags[3:0] == 4'b1100 || det_flags[3:0] == 4'b0011)); // R5
endmodule

bind swflow_ctrl swflow_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_tx_mode(cfg_tx_mode),
  .rx_valid(rx_valid), .tx_pause(tx_pause), .ins_valid(ins_valid),
  .fwd_valid(fwd_valid), .det_flags(det_flags)
);

// File: tb/swflow_ctrl_bench.sv
module swflow_ctrl_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_en = 1'b0;
  logic [1:0] cfg_rx_mode = 2'b00, cfg_tx_mode = 2'b00;
  logic [7:0] cfg_levels = 8'h14;
  logic [7:0] cfg_xon1 = 8'h11, cfg_xon2 = 8'h12, cfg_xoff1 = 8'h13, cfg_xoff2 = 8'h14;
  logic rx_valid = 1'b0, rx_break = 1'b0;
  logic [7:0] rx_char = 8'h00, fifo_level = 8'd0;
  logic tx_pause, ins_valid, fwd_valid;
  logic [7:0] ins_char, fwd_char;
  logic [4:0] det_flags;

  swflow_ctrl u_swflow_ctrl (.*);

  always #5 clk = ~clk;

  typedef struct { int cyc; int kind; int val; string req; } item_t;
  item_t q[$];
  int cyc = 0, checks = 0, fails = 0;
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic push(input int c, input int k, input int v, input string req);
    item_t it;
    it.cyc = c; it.kind = k; it.val = v; it.req = req;
    q.push_back(it);
  endtask

  task automatic cmp(input int k, input int v);
    item_t it;
    checks++;
    if (q.size() == 0) begin
      fails++;
      $display("FAIL unexpected kind %0d value %0h at cycle %0d (expected nothing)", k, v, cyc);
    end else begin
      it = q.pop_front();
      if (it.cyc != cyc || it.kind != k || it.val != v) begin
        fails++;
        $display("FAIL %s: got kind %0d val %0h cyc %0d, expected kind %0d val %0h cyc %0d",
                 it.req, k, v, cyc, it.kind, it.val, it.cyc);
      end
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    while (q.size() > 0 && q[0].cyc < cyc) begin
      checks++; fails++;
      $display("FAIL %s: missing kind %0d val %0h due cycle %0d, actual none", q[0].req, q[0].kind, q[0].val, q[0].cyc);
      void'(q.pop_front());
    end
    if (fwd_valid) cmp(0, int'(fwd_char));
    if (ins_valid) cmp(1, int'(ins_char));
    if (det_flags != 5'd0) cmp(2, int'(det_flags));
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic rx(input logic [7:0] ch, input bit brk, input int f1, input int f2,
                    input int fl, input string req);
    @(negedge clk);
    if (f1 >= 0) push(cyc + 1, 0, f1, req);
    if (fl != 0) push(cyc + 1, 2, fl, req);
    if (f2 >= 0) push(cyc + 2, 0, f2, req);
    rx_valid = 1'b1; rx_char = ch; rx_break = brk;
    @(negedge clk);
    rx_valid = 1'b0; rx_break = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic lvl(input int v, input int i1, input int i2, input string req);
    @(negedge clk);
    if (i1 >= 0) push(cyc + 1, 1, i1, req);
    if (i2 >= 0) push(cyc + 2, 1, i2, req);
    fifo_level = v[7:0];
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run();
    if (q.size() > 0) begin
      checks++; fails++;
      $display("FAIL end: %0d expected items never seen (expected 0)", q.size());
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: run did not end (actual hung, expected done)");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 pause", int'(tx_pause), 0);
    check("R1 fwd", int'(fwd_valid), 0);
    check("R1 ins", int'(ins_valid), 0);
    check("R1 flags", int'(det_flags), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R2: disabled and mode 00 pass codes through
    cfg_rx_mode = 2'b10;
    rx(8'h13, 0, 'h13, -1, 0, "R2 disabled");
    check("R2 pause disabled", int'(tx_pause), 0);
    cfg_en = 1'b1; cfg_rx_mode = 2'b00;
    rx(8'h13, 0, 'h13, -1, 0, "R2 mode00");
    check("R2 pause mode00", int'(tx_pause), 0);
    // R3: set 1 single codes
    cfg_rx_mode = 2'b10;
    rx(8'h41, 0, 'h41, -1, 0, "R3 data");
    rx(8'h13, 0, -1, -1, 'b00100, "R3 xoff1");
    check("R3 paused", int'(tx_pause), 1);
    rx(8'h14, 0, 'h14, -1, 0, "R3 set2 passes");
    rx(8'h11, 0, -1, -1, 'b00001, "R3 xon1");
    check("R3 resumed", int'(tx_pause), 0);
    // R4: set 2 single codes
    cfg_rx_mode = 2'b01;
    rx(8'h13, 0, 'h13, -1, 0, "R4 set1 passes");
    rx(8'h14, 0, -1, -1, 'b01000, "R4 xoff2");
    check("R4 paused", int'(tx_pause), 1);
    rx(8'h12, 0, -1, -1, 'b00010, "R4 xon2");
    check("R4 resumed", int'(tx_pause), 0);
    // R5: pairs
    cfg_rx_mode = 2'b11;
    rx(8'h13, 0, -1, -1, 0, "R5 first alone");
    check("R5 first no pause", int'(tx_pause), 0);
    rx(8'h14, 0, -1, -1, 'b01100, "R5 xoff pair");
    check("R5 paused", int'(tx_pause), 1);
    rx(8'h11, 0, -1, -1, 0, "R5 xon first");
    check("R5 still paused", int'(tx_pause), 1);
    rx(8'h12, 0, -1, -1, 'b00011, "R5 xon pair");
    check("R5 resumed", int'(tx_pause), 0);
    // R6: broken pairs
    rx(8'h13, 0, -1, -1, 0, "R6 hold");
    rx(8'h55, 0, 'h13, 'h55, 0, "R6 broken");
    rx(8'h11, 0, -1, -1, 0, "R6 hold xon1");
    rx(8'h13, 0, 'h11, -1, 0, "R6 new first");
    rx(8'h14, 0, -1, -1, 'b01100, "R6 rehold completes");
    check("R6 paused", int'(tx_pause), 1);
    // R2: leaving the mode drops the pause
    cfg_rx_mode = 2'b00;
    @(negedge clk);
    check("R2 pause drop", int'(tx_pause), 0);
    // R7: break
    cfg_rx_mode = 2'b10;
    @(negedge clk);
    rx(8'h13, 1, 'h13, -1, 'b10000, "R7 break");
    check("R7 no pause", int'(tx_pause), 0);
    // R8/R9: halt 32, resume 8
    cfg_tx_mode = 2'b10;
    lvl(20, -1, -1, "R8 below");
    lvl(31, -1, -1, "R8 edge");
    lvl(32, 'h13, -1, "R8 halt");
    lvl(60, -1, -1, "R8 no repeat");
    lvl(9, -1, -1, "R9 above resume");
    lvl(8, 'h11, -1, "R9 resume");
    lvl(4, -1, -1, "R9 no repeat");
    cfg_tx_mode = 2'b01;
    lvl(40, 'h14, -1, "R8 set2");
    lvl(0, 'h12, -1, "R9 set2");
    // R10: pairs
    cfg_tx_mode = 2'b11;
    lvl(32, 'h13, 'h14, "R10 xoff pair");
    lvl(0, 'h11, 'h12, "R10 xon pair");
    // R11
    cfg_tx_mode = 2'b00;
    lvl(100, -1, -1, "R11 mode00");
    lvl(0, -1, -1, "R11 mode00 low");
    cfg_en = 1'b0; cfg_tx_mode = 2'b10;
    lvl(100, -1, -1, "R11 disabled");
    lvl(0, -1, -1, "R11 disabled low");
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule